// File: doc/BRIEF.md
# Memory-Mapped Register Bank Slave

This block is a synchronous slave that sits on a simple word-addressed bus. The bus has a clock, a synchronous active-high reset, an address, write data, read data, and separate single-cycle read and write request strobes. Each request type has its own acknowledge. The address decodes to four word registers and a 16-word internal RAM window. Each register behaves according to its access kind:

| Address | Register | Access |
|---|---|---|
| 0 | Control | Read-write |
| 1 | Status | Read-only, taken from an input port |
| 2 | Identifier | Constant, reads `0xCAFE0001` |
| 3 | Command | Write-only, with a write-strobe output |
| 16 to 31 | RAM window | Read-write |

A write to an ordinary register is acknowledged in the cycle after it is accepted. A write to the RAM window goes through a two-cycle handshake, run by a small state machine with two states. `WR_IDLE` accepts requests. `WR_RAM_HOLD` is the delay cycle in which the RAM write enable is high. The machine has three transitions:
- `WR_IDLE` to `WR_IDLE` on a register write or an unmapped write. `wr_ack` follows one cycle later.
- `WR_IDLE` to `WR_RAM_HOLD` on a RAM write.
- `WR_RAM_HOLD` to `WR_IDLE` unconditionally, raising `wr_ack` as it leaves.

Reads run on a separate path and are always answered one cycle after acceptance. The read data is defined only in the cycle in which `rd_ack` is high.

Top module: `regbank_slave`

## Requirements
- R1: A read is accepted on a clock edge where `rd_req` is 1 and `rd_ack` is 0. `rd_ack` is then 1 for exactly the following cycle. A request that is still held during the acknowledge cycle is dropped.
- R2: In the acknowledge cycle, `rdata` holds the value for the address read:
  - Address 0 returns the stored control value.
  - Address 1 returns `status_in` as sampled at the accepting edge.
  - Address 2 returns 32'hCAFE0001.
- R3: Reads of address 3 (write-only) and of the unmapped addresses 4 to 15 return zero, with a normal acknowledge.
- R4: A write is accepted on an edge where `wr_req` is 1, `wr_ack` is 0 and no RAM write is pending. For addresses 0 to 15, `wr_ack` is 1 for exactly the next cycle. A write to address 0 loads `wdata` into `ctrl_out`.
- R5: Writes to addresses 1, 2 and 4 to 15 are acknowledged like any other write. They change neither `ctrl_out` nor `cmd_out`, nor the values read back from addresses 1 and 2.
- R6: After reset, `ctrl_out` is 32'h000000A5, `cmd_out` is 0, and `rd_ack`, `wr_ack` and `cmd_strobe` are 0.
- R7: A write to address 3 loads `cmd_out` and raises `cmd_strobe` for exactly the cycle after acceptance. At all other times `cmd_strobe` is 0.
- R8: A write to addresses 16 to 31 stores `wdata` at RAM word (address − 16). `wr_ack` stays 0 in the first cycle after acceptance and is 1 in the second. Write requests made in between are dropped.
- R9: A read of addresses 16 to 31 returns the stored RAM word in the acknowledge cycle that follows the request.
- R10: A read and a write presented in the same cycle are both accepted, and each is acknowledged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rd_req | input | 1 | Read request strobe |
| wr_req | input | 1 | Write request strobe |
| status_in | input | 32 | Source of the read-only status register |
| rdata | output | 32 | Read data, valid while `rd_ack` is 1 |
| rd_ack | output | 1 | Read acknowledge |
| wr_ack | output | 1 | Write acknowledge |
| ctrl_out | output | 32 | Stored control register |
| cmd_out | output | 32 | Stored command register |
| cmd_strobe | output | 1 | One-cycle pulse on a command write |

## Verification
The bench sweeps all 32 addresses for reads and fills and reads back the whole RAM window with an arithmetic pattern.

It holds requests across the acknowledge cycle. A design that re-accepts a held request would show two back-to-back acks or a doubled write.

It times the RAM write acknowledge to the exact cycle. A design that collapses the handshake to one cycle, or never leaves the hold state, fails at that cycle.

It writes to read-only, constant and unmapped addresses. A decoder that lets such writes through would corrupt the control, command or identifier values, and one that refuses to acknowledge them would hang the bus.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    // Decoded target of the current bus address
    typedef enum logic [2:0] {
        RG_CTRL,
        RG_STATUS,
        RG_ID,
        RG_CMD,
        RG_RAM,
        RG_NONE
    } region_e;

    // Write handshake states
    typedef enum logic {
        WR_IDLE,
        WR_RAM_HOLD
    } wr_state_e;

endpackage

// File: rtl/regbank_ram.sv
module regbank_ram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/regbank_wr_ctrl.sv
module regbank_wr_ctrl
    import regbank_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          IDX_W      = 4,
    parameter logic [31:0] CTRL_RESET = 32'h0000_00A5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  region_e           region,
    input  logic [IDX_W-1:0]  ram_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_ack,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] cmd_q,
    output logic              cmd_strobe,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_wa,
    output logic [DATA_W-1:0] ram_wd
);

    wr_state_e state, state_nx;
    logic      accept;

    assign accept = wr_req && !wr_ack && (state == WR_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            WR_IDLE:     if (accept && region == RG_RAM) state_nx = WR_RAM_HOLD;
            WR_RAM_HOLD: state_nx = WR_IDLE;
            default:     state_nx = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= WR_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ack     <= 1'b0;
            ctrl_q     <= CTRL_RESET[DATA_W-1:0];
            cmd_q      <= '0;
            cmd_strobe <= 1'b0;
            ram_we     <= 1'b0;
            ram_wa     <= '0;
            ram_wd     <= '0;
        end else begin
            wr_ack     <= 1'b0;
            cmd_strobe <= 1'b0;
            ram_we     <= 1'b0;
            unique case (state)
                WR_IDLE: begin
                    if (accept) begin
                        if (region == RG_RAM) begin
                            ram_we <= 1'b1;
                            ram_wa <= ram_idx;
                            ram_wd <= wdata;
                        end else begin
                            wr_ack <= 1'b1;
                            if (region == RG_CTRL) ctrl_q <= wdata;
                            if (region == RG_CMD) begin
                                cmd_q      <= wdata;
                                cmd_strobe <= 1'b1;
                            end
                        end
                    end
                end
                WR_RAM_HOLD: wr_ack <= 1'b1;
                default: ;
            endcase
        end
    end

    // R4
    wr_ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ack |=> !wr_ack);
    // R7
    cmd_strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |=> !cmd_strobe);
    // R8
    ram_hold_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WR_RAM_HOLD) |=> (wr_ack && state == WR_IDLE));
    // R8
    ram_we_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (state == WR_RAM_HOLD && !wr_ack));
    // R6
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ctrl_q == CTRL_RESET[DATA_W-1:0] && cmd_q == '0 && !wr_ack && !cmd_strobe));

endmodule

// File: rtl/regbank_rd_ctrl.sv
module regbank_rd_ctrl
    import regbank_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'hCAFE_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  region_e           region,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] ram_q,
    output logic              rd_ack,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rdata_q;
    logic              from_ram;
    logic              accept;

    assign accept = rd_req && !rd_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ack   <= 1'b0;
            from_ram <= 1'b0;
            rdata_q  <= 'x;
        end else begin
            rd_ack   <= accept;
            from_ram <= 1'b0;
            rdata_q  <= 'x;
            if (accept) begin
                unique case (region)
                    RG_CTRL:   rdata_q <= ctrl_q;
                    RG_STATUS: rdata_q <= status_in;
                    RG_ID:     rdata_q <= ID_VALUE[DATA_W-1:0];
                    RG_RAM:    from_ram <= 1'b1;
                    default:   rdata_q <= '0;
                endcase
            end
        end
    end

    assign rdata = from_ram ? ram_q : rdata_q;

    // R1
    rd_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> rd_ack);
    // R1
    rd_ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> !rd_ack);
    // R6
    rd_reset_chk: assert property (@(posedge clk)
        rst |=> !rd_ack);

endmodule

// File: rtl/regbank_slave.sv
module regbank_slave
    import regbank_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 5,
    parameter int          RAM_DEPTH  = 16,
    parameter int          RAM_BASE   = 16,
    parameter logic [31:0] CTRL_RESET = 32'h0000_00A5,
    parameter logic [31:0] ID_VALUE   = 32'hCAFE_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_ack,
    output logic              wr_ack,
    output logic [DATA_W-1:0] ctrl_out,
    output logic [DATA_W-1:0] cmd_out,
    output logic              cmd_strobe
);

    localparam int IDX_W = $clog2(RAM_DEPTH);

    region_e           region;
    logic [IDX_W-1:0]  ram_idx;
    logic              ram_we;
    logic [IDX_W-1:0]  ram_wa;
    logic [DATA_W-1:0] ram_wd;
    logic [DATA_W-1:0] ram_q;

    assign ram_idx = addr[IDX_W-1:0];

    always_comb begin
        if (int'(addr) >= RAM_BASE && int'(addr) < RAM_BASE + RAM_DEPTH) region = RG_RAM;
        else if (int'(addr) == 0) region = RG_CTRL;
        else if (int'(addr) == 1) region = RG_STATUS;
        else if (int'(addr) == 2) region = RG_ID;
        else if (int'(addr) == 3) region = RG_CMD;
        else                      region = RG_NONE;
    end

    regbank_wr_ctrl #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .CTRL_RESET(CTRL_RESET)
    ) u_wr (
        .clk(clk), .rst(rst), .wr_req(wr_req), .region(region),
        .ram_idx(ram_idx), .wdata(wdata), .wr_ack(wr_ack),
        .ctrl_q(ctrl_out), .cmd_q(cmd_out), .cmd_strobe(cmd_strobe),
        .ram_we(ram_we), .ram_wa(ram_wa), .ram_wd(ram_wd)
    );

    regbank_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(ram_wd),
        .raddr(ram_idx), .rdata(ram_q)
    );

    regbank_rd_ctrl #(.DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_rd (
        .clk(clk), .rst(rst), .rd_req(rd_req), .region(region),
        .ctrl_q(ctrl_out), .status_in(status_in), .ram_q(ram_q),
        .rd_ack(rd_ack), .rdata(rdata)
    );

    // R10
    dual_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack && wr_req && !wr_ack && !ram_we && region != RG_RAM)
        |=> (rd_ack && wr_ack));

endmodule

// File: tb/regbank_slave_tb.sv
`timescale 1ns/1ps
module regbank_slave_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  addr;
    logic [31:0] wdata, status_in, rdata, ctrl_out, cmd_out;
    logic        rd_req, wr_req, rd_ack, wr_ack, cmd_strobe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [31:0] ID_C   = 32'hCAFE_0001;
    localparam logic [31:0] CTRL_R = 32'h0000_00A5;

    always #2.5 clk = ~clk;

    regbank_slave u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd_req(rd_req),
        .wr_req(wr_req), .status_in(status_in), .rdata(rdata), .rd_ack(rd_ack),
        .wr_ack(wr_ack), .ctrl_out(ctrl_out), .cmd_out(cmd_out),
        .cmd_strobe(cmd_strobe)
    );

    function automatic logic [31:0] ram_pat(input int i);
        return (32'(i) * 32'h0101_0101) ^ 32'h5A00_00C3;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // single read, checks ack cycle data and the cycle after
    task automatic do_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_req = 1'b1;
        @(posedge clk); #1;
        rd_req = 1'b0;
        chk(rd_ack === 1'b1, {tag, " rd_ack"}, 32'(rd_ack), 32'd1);
        chk(rdata === exp, {tag, " rdata"}, rdata, exp);
        @(posedge clk); #1;
        chk(rd_ack === 1'b0, {tag, " rd_ack drop"}, 32'(rd_ack), 32'd0);
    endtask

    // register-region write: ack one cycle after acceptance
    task automatic do_wr_reg(input logic [4:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        addr = a; wdata = d; wr_req = 1'b1;
        @(posedge clk); #1;
        wr_req = 1'b0;
        chk(wr_ack === 1'b1, {tag, " wr_ack"}, 32'(wr_ack), 32'd1);
        chk(cmd_strobe === (a == 5'd3), {tag, " cmd_strobe"}, 32'(cmd_strobe), 32'(a == 5'd3));
        @(posedge clk); #1;
        chk(wr_ack === 1'b0 && cmd_strobe === 1'b0, {tag, " ack/strobe drop"},
            {30'd0, wr_ack, cmd_strobe}, 32'd0);
    endtask

    // RAM write: request held two edges, ack only in second cycle
    task automatic do_wr_ram(input logic [4:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        addr = a; wdata = d; wr_req = 1'b1;
        @(posedge clk); #1;
        chk(wr_ack === 1'b0, {tag, " R8 no ack in hold"}, 32'(wr_ack), 32'd0);
        wdata = ~d;  // held request during hold must be dropped
        @(posedge clk); #1;
        wr_req = 1'b0;
        chk(wr_ack === 1'b1, {tag, " R8 ack second cycle"}, 32'(wr_ack), 32'd1);
        @(posedge clk); #1;
        chk(wr_ack === 1'b0, {tag, " R8 ack drop"}, 32'(wr_ack), 32'd0);
    endtask

    initial begin
        rst = 1'b1; addr = '0; wdata = '0; rd_req = 1'b0; wr_req = 1'b0;
        status_in = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #1;
        // R6 reset state
        chk(ctrl_out === CTRL_R, "R6 ctrl reset", ctrl_out, CTRL_R);
        chk(cmd_out === 32'd0, "R6 cmd reset", cmd_out, 32'd0);
        chk({rd_ack, wr_ack, cmd_strobe} === 3'b000, "R6 flags reset",
            32'({rd_ack, wr_ack, cmd_strobe}), 32'd0);
        @(negedge clk); rst = 1'b0;

        // R2 R3 read sweep of register region
        do_read(5'd0, CTRL_R, "R2 ctrl");
        do_read(5'd1, 32'h1234_5678, "R2 status");
        status_in = 32'hDEAD_BEEF;
        do_read(5'd1, 32'hDEAD_BEEF, "R2 status new");
        do_read(5'd2, ID_C, "R2 id");
        for (int a = 3; a < 16; a++) do_read(5'(a), 32'd0, "R3 zero read");

        // R4 control write
        do_wr_reg(5'd0, 32'h0F0F_3C3C, "R4 ctrl write");
        chk(ctrl_out === 32'h0F0F_3C3C, "R4 ctrl_out", ctrl_out, 32'h0F0F_3C3C);
        do_read(5'd0, 32'h0F0F_3C3C, "R4 ctrl readback");

        // R7 command write
        do_wr_reg(5'd3, 32'hA1B2_C3D4, "R7 cmd write");
        chk(cmd_out === 32'hA1B2_C3D4, "R7 cmd_out", cmd_out, 32'hA1B2_C3D4);
        do_read(5'd3, 32'd0, "R3 cmd reads zero");

        // R5 ignored writes
        do_wr_reg(5'd1, 32'h1111_1111, "R5 status write");
        do_wr_reg(5'd2, 32'h2222_2222, "R5 id write");
        for (int a = 4; a < 16; a++) do_wr_reg(5'(a), 32'h3333_0000 | 32'(a), "R5 unmapped write");
        chk(ctrl_out === 32'h0F0F_3C3C, "R5 ctrl kept", ctrl_out, 32'h0F0F_3C3C);
        chk(cmd_out === 32'hA1B2_C3D4, "R5 cmd kept", cmd_out, 32'hA1B2_C3D4);
        do_read(5'd2, ID_C, "R5 id kept");
        do_read(5'd1, 32'hDEAD_BEEF, "R5 status kept");

        // R8 R9 RAM fill and readback
        for (int i = 0; i < 16; i++) do_wr_ram(5'(16 + i), ram_pat(i), "R8 ram write");
        for (int i = 0; i < 16; i++) do_read(5'(16 + i), ram_pat(i), "R9 ram read");
        do_wr_ram(5'd21, 32'h7777_AAAA, "R8 ram overwrite");
        do_read(5'd21, 32'h7777_AAAA, "R9 ram overwrite read");
        do_read(5'd22, ram_pat(6), "R9 neighbour kept");

        // R1 held read: accept, drop, accept
        @(negedge clk);
        addr = 5'd2; rd_req = 1'b1;
        @(posedge clk); #1;
        chk(rd_ack === 1'b1, "R1 held first ack", 32'(rd_ack), 32'd1);
        @(posedge clk); #1;
        chk(rd_ack === 1'b0, "R1 held dropped", 32'(rd_ack), 32'd0);
        @(posedge clk); #1;
        rd_req = 1'b0;
        chk(rd_ack === 1'b1 && rdata === ID_C, "R1 held re-accept", rdata, ID_C);
        @(posedge clk); #1;

        // R4 held write: second edge dropped while acked
        @(negedge clk);
        addr = 5'd3; wdata = 32'h0000_0042; wr_req = 1'b1;
        @(posedge clk); #1;
        chk(wr_ack === 1'b1 && cmd_strobe === 1'b1, "R4 held first ack",
            {30'd0, wr_ack, cmd_strobe}, 32'd3);
        @(posedge clk); #1;
        wr_req = 1'b0;
        chk(wr_ack === 1'b0 && cmd_strobe === 1'b0, "R7 no second strobe",
            {30'd0, wr_ack, cmd_strobe}, 32'd0);

        // R10 simultaneous read and write
        @(negedge clk);
        addr = 5'd0; wdata = 32'h5555_6666; rd_req = 1'b1; wr_req = 1'b1;
        @(posedge clk); #1;
        rd_req = 1'b0; wr_req = 1'b0;
        chk(rd_ack === 1'b1 && wr_ack === 1'b1, "R10 both acked",
            {30'd0, rd_ack, wr_ack}, 32'd3);
        chk(rdata === 32'h0F0F_3C3C, "R10 read sees old ctrl", rdata, 32'h0F0F_3C3C);
        chk(ctrl_out === 32'h5555_6666, "R10 ctrl written", ctrl_out, 32'h5555_6666);
        @(posedge clk); #1;

        // R6 reset again mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk(ctrl_out === CTRL_R && cmd_out === 32'd0, "R6 re-reset", ctrl_out, CTRL_R);
        @(negedge clk); rst = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule